// File: doc/BRIEF.md
# Memory PHY Training Sequencer

This block walks one rank of a DDR memory channel through physical-layer training. Software writes a single 32-bit control word. A write with the start bit set launches a run of up to four training steps in a fixed order. For each step that is not skipped, the block sends a one-cycle start pulse to an external training engine. It then waits for that engine's completion pulse, or for a configurable timeout. A mode bit hands the stepping over to software, which then names one step at a time through a next-state field.

The same control word also carries some one-shot actions that have no part in training:

- a pulse that asks for impedance calibration of a rank,
- a pulse that asks for ZQ long calibration of a rank,
- a pulse that resets the FIFO pointers.

It also holds two levels. One drives the DRAM clock-enable pins before initialization is declared complete. The other gates the early-valid strobe of the read path. Status (busy, failed, current step code and trained rank) appears on dedicated outputs.

Top module: `phy_train_seq`

## Requirements
- R1: Out of reset the following are all 0: `busy`, `failed`, `cur_state`, `step_start`, `cke_out`, `cfg_rdata`, every pulse output and `rx_vld_out`.
- R2: Step codes are 1 = read DQ-DQS, 2 = receive-enable bitlock, 3 = write leveling and 4 = write DQ-DQS. A write with bit 0 = 1 and bit 1 = 0 starts a run when the block is idle. The run visits the unskipped steps in ascending code order. Each visit raises bit (code-1) of `step_start` for one cycle, two clock edges after the write (the first one) or one edge after the previous step ends. While a step runs, `cur_state` shows its code and `busy` is high. `train_rank` holds the value of bits 7:5 captured when the run starts. After the last step the block returns to code 0 with `busy` low.
- R3: Skip bits: bit 12 skips step 1, bit 11 skips step 2, bit 13 skips step 3, bit 14 skips step 4. A start with all four set launches nothing and leaves the block idle.
- R4: With bit 1 = 1, a write whose bits 4:2 hold an unskipped code 1..4 runs only that step and then returns to idle. In this mode bit 0 is ignored, and so are codes 0, 5, 6 and 7.
- R5: Only the completion input of the active step ends it. A start or step command written while `busy` is high is ignored, and `train_rank` keeps its value.
- R6: A step times out when its completion has not arrived within `TMO_CYC` cycles of its start pulse. A timeout sets `failed`. If bit 8 is 1 and `auto_rst_dis` is 0, the run stops and the block goes idle. Otherwise the run continues with the next step. An accepted start or step command clears `failed`.
- R7: Writing bit 16 (or bit 15) as 1 pulses `cal_rcomp` (or `cal_zqcl`) for one cycle after the next edge. At the same time `cal_rank` takes the written bits 7:5. Both bits read back as 0.
- R8: While bit 17 is 1 and `init_done` is 0, every `cke_out` bit is 1, one edge after the condition holds. Otherwise every bit is 0.
- R9: Writing bit 10 as 1 pulses `fifo_rst` for one cycle after the next edge. The bit reads back as 0.
- R10: `rx_vld_out` equals `rx_vld_in` AND NOT bit 9, registered one cycle.
- R11: `cfg_rdata` returns bits 17, 14..11, 9, 8, 7:5, 4:2 and 1 as last written. Bits 31:18, 16, 15, 10 and 0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word readback |
| init_done | input | 1 | Initialization complete; releases clock-enable control |
| auto_rst_dis | input | 1 | When high, a timeout never halts the run |
| step_start | output | 4 | One-cycle start pulse per training step |
| step_done | input | 4 | Completion pulse per training step |
| busy | output | 1 | A step is in progress |
| failed | output | 1 | A step timed out since the last accepted command |
| cur_state | output | 3 | Code of the active step, 0 when idle |
| train_rank | output | 3 | Rank of the current or last run |
| cal_rcomp | output | 1 | Impedance calibration request pulse |
| cal_zqcl | output | 1 | ZQ long calibration request pulse |
| cal_rank | output | 3 | Rank for the calibration request |
| fifo_rst | output | 1 | TX/RX FIFO pointer and bubble reset pulse |
| cke_out | output | NUM_CKE | DRAM clock-enable drive |
| rx_vld_in | input | 1 | Early-valid from the RX FIFOs |
| rx_vld_out | output | 1 | Gated early-valid to the read datapath |

## Verification
A wrong step order, or a skip bit decoded to the wrong step, shows up as soon as the next start pulse appears. That pulse lands on the wrong bit of `step_start`, and the scoreboard of expected step codes flags it. A sequencer that misses a completion or miscounts the timeout stays busy too long or too short. The `failed` and `busy` values then disagree at the end of the run, a few tens of cycles later. Decode errors in the one-shot fields show on the pulse outputs one edge after the write, and in the readback word at once.

// File: rtl/phy_train_pkg.sv
package phy_train_pkg;

  localparam int CTRL_W   = 32;
  localparam int N_STEPS  = 4;
  localparam int CODE_W   = 3;
  localparam int RANK_W   = 3;

  // control word bit positions (software decodes these)
  localparam int B_TRAIN  = 0;
  localparam int B_MANUAL = 1;
  localparam int F_NXT_LO = 2;
  localparam int F_RNK_LO = 5;
  localparam int B_STOP   = 8;
  localparam int B_IGNRX  = 9;
  localparam int B_FIFO   = 10;
  localparam int B_SK_RCV = 11;
  localparam int B_SK_RDQ = 12;
  localparam int B_SK_WLV = 13;
  localparam int B_SK_WDQ = 14;
  localparam int B_ZQ     = 15;
  localparam int B_RCOMP  = 16;
  localparam int B_CKE    = 17;
  localparam int USED_W   = 18;

  typedef enum logic [CODE_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_RDDQ  = 3'd1,
    ST_RCVEN = 3'd2,
    ST_WRLVL = 3'd3,
    ST_WRDQ  = 3'd4
  } step_e;

  // skip[i] applies to step code i+1
  typedef struct packed {
    logic                cke;
    logic [N_STEPS-1:0]  skip;
    logic                ign_rx;
    logic                stop;
    logic [RANK_W-1:0]   rank;
    logic [CODE_W-1:0]   nxt;
    logic                manual;
  } ctrl_t;

  function automatic logic [CODE_W-1:0] next_step(input logic [CODE_W-1:0] from,
                                                   input logic [N_STEPS-1:0] skip);
    logic [CODE_W-1:0] r;
    r = '0;
    for (int i = N_STEPS; i >= 1; i--) begin
      if ((CODE_W'(i) > from) && !skip[i-1]) r = CODE_W'(i);
    end
    return r;
  endfunction

  function automatic logic step_ok(input logic [CODE_W-1:0] code,
                                   input logic [N_STEPS-1:0] skip);
    logic r;
    r = 1'b0;
    for (int i = 1; i <= N_STEPS; i++) begin
      if (code == CODE_W'(i)) r = !skip[i-1];
    end
    return r;
  endfunction

endpackage

// File: rtl/ptr_ctrl_regs.sv
module ptr_ctrl_regs
  import phy_train_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [USED_W-1:0]       wdata,
  output ctrl_t                   ctrl,
  output logic                    train_p,
  output logic                    step_p,
  output logic                    cal_rcomp,
  output logic                    cal_zqcl,
  output logic [RANK_W-1:0]       cal_rank,
  output logic                    fifo_rst,
  output logic [CTRL_W-1:0]       rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      train_p   <= 1'b0;
      step_p    <= 1'b0;
      cal_rcomp <= 1'b0;
      cal_zqcl  <= 1'b0;
      cal_rank  <= '0;
      fifo_rst  <= 1'b0;
    end else begin
      train_p   <= we & wdata[B_TRAIN] & ~wdata[B_MANUAL];
      step_p    <= we & wdata[B_MANUAL];
      cal_rcomp <= we & wdata[B_RCOMP];
      cal_zqcl  <= we & wdata[B_ZQ];
      fifo_rst  <= we & wdata[B_FIFO];
      if (we) begin
        cal_rank     <= wdata[F_RNK_LO +: RANK_W];
        ctrl.cke     <= wdata[B_CKE];
        ctrl.skip    <= {wdata[B_SK_WDQ], wdata[B_SK_WLV], wdata[B_SK_RCV], wdata[B_SK_RDQ]};
        ctrl.ign_rx  <= wdata[B_IGNRX];
        ctrl.stop    <= wdata[B_STOP];
        ctrl.rank    <= wdata[F_RNK_LO +: RANK_W];
        ctrl.nxt     <= wdata[F_NXT_LO +: CODE_W];
        ctrl.manual  <= wdata[B_MANUAL];
      end
    end
  end

  always_comb begin
    rdata                       = '0;
    rdata[B_CKE]                = ctrl.cke;
    rdata[B_SK_WDQ]             = ctrl.skip[3];
    rdata[B_SK_WLV]             = ctrl.skip[2];
    rdata[B_SK_RCV]             = ctrl.skip[1];
    rdata[B_SK_RDQ]             = ctrl.skip[0];
    rdata[B_IGNRX]              = ctrl.ign_rx;
    rdata[B_STOP]               = ctrl.stop;
    rdata[F_RNK_LO +: RANK_W]   = ctrl.rank;
    rdata[F_NXT_LO +: CODE_W]   = ctrl.nxt;
    rdata[B_MANUAL]             = ctrl.manual;
  end

endmodule

// File: rtl/ptr_step_timer.sv
module ptr_step_timer #(
  parameter int TMO_CYC = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);

  localparam int CNT_W = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= '0;
    else if (cnt != LAST)  cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LAST);

endmodule

// File: rtl/ptr_seq_fsm.sv
module ptr_seq_fsm
  import phy_train_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  ctrl_t                ctrl,
  input  logic                 train_p,
  input  logic                 step_p,
  input  logic [N_STEPS-1:0]   step_done,
  input  logic                 expired,
  input  logic                 auto_rst_dis,
  output logic                 launch,
  output logic [N_STEPS-1:0]   step_start,
  output logic [CODE_W-1:0]    cur_state,
  output logic                 busy,
  output logic                 failed,
  output logic [RANK_W-1:0]    train_rank
);

  logic [CODE_W-1:0] target;
  logic              hit, tout, halt, end_step, accept, man_ok, manual_run;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < N_STEPS; i++) begin
      if (cur_state == CODE_W'(i + 1)) hit = step_done[i];
    end
    tout     = busy & ~hit & expired;
    halt     = tout & ctrl.stop & ~auto_rst_dis;
    end_step = busy & (hit | tout);
    man_ok   = step_ok(ctrl.nxt, ctrl.skip);
    accept   = ~busy & (train_p | (step_p & man_ok));
    if (busy)
      target = (manual_run | halt) ? ST_IDLE : next_step(cur_state, ctrl.skip);
    else if (train_p)
      target = next_step(ST_IDLE, ctrl.skip);
    else
      target = ctrl.nxt;
    launch = (end_step | accept) & (target != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_state  <= ST_IDLE;
      busy       <= 1'b0;
      failed     <= 1'b0;
      manual_run <= 1'b0;
      train_rank <= '0;
      step_start <= '0;
    end else begin
      step_start <= '0;
      if (end_step) begin
        if (tout) failed <= 1'b1;
        cur_state <= target;
        busy      <= (target != ST_IDLE);
      end else if (accept) begin
        failed     <= 1'b0;
        train_rank <= ctrl.rank;
        manual_run <= step_p;
        cur_state  <= target;
        busy       <= (target != ST_IDLE);
      end
      if (launch) step_start <= N_STEPS'(1) << (target - 3'd1);
    end
  end

endmodule

// File: rtl/phy_train_seq.sv
module phy_train_seq
  import phy_train_pkg::*;
#(
  parameter int NUM_CKE = 4,
  parameter int TMO_CYC = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  input  logic               init_done,
  input  logic               auto_rst_dis,
  output logic [3:0]         step_start,
  input  logic [3:0]         step_done,
  output logic               busy,
  output logic               failed,
  output logic [2:0]         cur_state,
  output logic [2:0]         train_rank,
  output logic               cal_rcomp,
  output logic               cal_zqcl,
  output logic [2:0]         cal_rank,
  output logic               fifo_rst,
  output logic [NUM_CKE-1:0] cke_out,
  input  logic               rx_vld_in,
  output logic               rx_vld_out
);

  ctrl_t ctrl;
  logic  train_p, step_p, launch, expired;
  logic  unused_hi;

  assign unused_hi = ^cfg_wdata[CTRL_W-1:USED_W];

  ptr_ctrl_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .wdata     (cfg_wdata[USED_W-1:0]),
    .ctrl      (ctrl),
    .train_p   (train_p),
    .step_p    (step_p),
    .cal_rcomp (cal_rcomp),
    .cal_zqcl  (cal_zqcl),
    .cal_rank  (cal_rank),
    .fifo_rst  (fifo_rst),
    .rdata     (cfg_rdata)
  );

  ptr_step_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .load    (launch),
    .expired (expired)
  );

  ptr_seq_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .ctrl         (ctrl),
    .train_p      (train_p),
    .step_p       (step_p),
    .step_done    (step_done),
    .expired      (expired),
    .auto_rst_dis (auto_rst_dis),
    .launch       (launch),
    .step_start   (step_start),
    .cur_state    (cur_state),
    .busy         (busy),
    .failed       (failed),
    .train_rank   (train_rank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_out    <= '0;
      rx_vld_out <= 1'b0;
    end else begin
      cke_out    <= {NUM_CKE{ctrl.cke & ~init_done}};
      rx_vld_out <= rx_vld_in & ~ctrl.ign_rx;
    end
  end

endmodule

// File: rtl/ptr_chk.sv
module ptr_chk #(
  parameter int NUM_CKE = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cfg_we,
  input logic [31:0]        cfg_wdata,
  input logic [31:0]        cfg_rdata,
  input logic               init_done,
  input logic [3:0]         step_start,
  input logic               busy,
  input logic [2:0]         cur_state,
  input logic               cal_rcomp,
  input logic               cal_zqcl,
  input logic               fifo_rst,
  input logic [NUM_CKE-1:0] cke_out,
  input logic               rx_vld_in,
  input logic               rx_vld_out
);

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(step_start)); // R2
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (|step_start) |-> busy); // R2
  AST_START_CODE: assert property (@(posedge clk) disable iff (rst)
    (|step_start) |-> (step_start == (4'b1 << (cur_state - 3'd1)))); // R2
  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cur_state <= 3'd4); // R2
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cur_state == 3'd0)); // R1
  AST_RCOMP_SRC: assert property (@(posedge clk) disable iff (rst)
    cal_rcomp |-> $past(cfg_we && cfg_wdata[16])); // R7
  AST_ZQ_SRC: assert property (@(posedge clk) disable iff (rst)
    cal_zqcl |-> $past(cfg_we && cfg_wdata[15])); // R7
  AST_FIFO_SRC: assert property (@(posedge clk) disable iff (rst)
    fifo_rst |-> $past(cfg_we && cfg_wdata[10])); // R9
  AST_CKE_GATE: assert property (@(posedge clk) disable iff (rst)
    $past(init_done) |-> (cke_out == '0)); // R8
  AST_RX_GATE: assert property (@(posedge clk) disable iff (rst)
    rx_vld_out |-> $past(rx_vld_in && !cfg_rdata[9])); // R10

endmodule

bind phy_train_seq ptr_chk #(.NUM_CKE(NUM_CKE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .init_done  (init_done),
  .step_start (step_start),
  .busy       (busy),
  .cur_state  (cur_state),
  .cal_rcomp  (cal_rcomp),
  .cal_zqcl   (cal_zqcl),
  .fifo_rst   (fifo_rst),
  .cke_out    (cke_out),
  .rx_vld_in  (rx_vld_in),
  .rx_vld_out (rx_vld_out)
);

// File: tb/sim_phy_train_seq.sv
`timescale 1ns/1ps
module sim_phy_train_seq;

  localparam int NCKE = 4;
  localparam int TMO  = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        init_done = 1'b0;
  logic        auto_rst_dis = 1'b0;
  logic [3:0]  step_start;
  logic [3:0]  resp_done = '0;
  logic [3:0]  extra_done = '0;
  logic [3:0]  step_done;
  logic        busy, failed;
  logic [2:0]  cur_state, train_rank, cal_rank;
  logic        cal_rcomp, cal_zqcl, fifo_rst;
  logic [NCKE-1:0] cke_out;
  logic        rx_vld_in = 1'b0;
  logic        rx_vld_out;

  int n_vec = 0;
  int n_bad = 0;
  int exp_q[$];
  int lat[4] = '{2, 3, 1, 4};
  int pend[4] = '{0, 0, 0, 0};

  assign step_done = resp_done | extra_done;

  always #5 clk = ~clk;

  phy_train_seq #(.NUM_CKE(NCKE), .TMO_CYC(TMO)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .init_done(init_done), .auto_rst_dis(auto_rst_dis), .step_start(step_start),
    .step_done(step_done), .busy(busy), .failed(failed), .cur_state(cur_state),
    .train_rank(train_rank), .cal_rcomp(cal_rcomp), .cal_zqcl(cal_zqcl),
    .cal_rank(cal_rank), .fifo_rst(fifo_rst), .cke_out(cke_out),
    .rx_vld_in(rx_vld_in), .rx_vld_out(rx_vld_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    cfg_wdata = d;
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // training engine models: done pulse lat[k] cycles after start, never if 0
  initial begin
    forever begin
      @(negedge clk);
      for (int k = 0; k < 4; k++) begin
        resp_done[k] = 1'b0;
        if (step_start[k]) pend[k] = lat[k];
        else if (pend[k] > 0) begin
          pend[k]--;
          if (pend[k] == 0) resp_done[k] = 1'b1;
        end
      end
    end
  end

  // scoreboard monitor: every start pulse must match the next expected code
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && (|step_start)) begin
        int code;
        code = 0;
        for (int k = 0; k < 4; k++) if (step_start[k]) code = k + 1;
        if (exp_q.size() == 0) check("R2 unexpected start", code, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          check("R2/R3 start order", code, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 failed", failed, 0);
    check("R1 cur_state", cur_state, 0);
    check("R1 step_start", step_start, 0);
    check("R1 cke_out", cke_out, 0);
    check("R1 rdata", cfg_rdata, 0);
    check("R1 pulses", {cal_rcomp, cal_zqcl, fifo_rst, rx_vld_out}, 0);

    // R2 full automatic run, rank 2
    exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3); exp_q.push_back(4);
    wr(32'h0000_0041);
    @(negedge clk);
    check("R2 busy during run", busy, 1);
    check("R2 first code", cur_state, 1);
    wait_idle();
    check("R2 idle code", cur_state, 0);
    check("R2 rank", train_rank, 2);
    check("R2 no fail", failed, 0);
    check("R2 queue drained", exp_q.size(), 0);

    // R3 skip receive-enable (bit11) and write leveling (bit13)
    exp_q.push_back(1); exp_q.push_back(4);
    wr(32'h0000_2801);
    wait_idle();
    check("R3 partial skip drained", exp_q.size(), 0);
    // R3 all skipped
    wr(32'h0000_7801);
    repeat (3) @(negedge clk);
    check("R3 all skipped stays idle", {busy, cur_state}, 0);

    // R4 software-stepped: step 3 only
    exp_q.push_back(3);
    wr(32'h0000_000E);
    @(negedge clk);
    check("R4 manual code", cur_state, 3);
    wait_idle();
    check("R4 back to idle", {busy, cur_state}, 0);
    check("R4 queue drained", exp_q.size(), 0);
    wr(32'h0000_0003);  // start bit with manual mode, nxt=0: ignored
    repeat (3) @(negedge clk);
    check("R4 start ignored in manual", busy, 0);
    wr(32'h0000_001E);  // nxt=7: ignored
    repeat (3) @(negedge clk);
    check("R4 illegal code ignored", busy, 0);

    // R5 foreign done and busy-time commands are ignored
    lat[0] = 6;
    exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3); exp_q.push_back(4);
    wr(32'h0000_0041);
    @(negedge clk);
    extra_done = 4'b0010;
    @(negedge clk);
    extra_done = 4'b0000;
    check("R5 foreign done ignored", cur_state, 1);
    wr(32'h0000_00C1);
    @(negedge clk);
    check("R5 rank kept while busy", train_rank, 2);
    wait_idle();
    check("R5 queue drained", exp_q.size(), 0);
    lat[0] = 2;

    // R6 timeout with halt
    lat[1] = 0;
    exp_q.push_back(1); exp_q.push_back(2);
    wr(32'h0000_0101);
    wait_idle();
    check("R6 halt failed", failed, 1);
    check("R6 halt idle", cur_state, 0);
    check("R6 halt drained", exp_q.size(), 0);
    // R6 timeout carries on when auto_rst_dis is high
    auto_rst_dis = 1'b1;
    exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3); exp_q.push_back(4);
    wr(32'h0000_0101);
    wait_idle();
    check("R6 carry-on failed", failed, 1);
    check("R6 carry-on drained", exp_q.size(), 0);
    auto_rst_dis = 1'b0;
    lat[1] = 3;
    exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(3); exp_q.push_back(4);
    wr(32'h0000_0001);
    wait_idle();
    check("R6 failed cleared", failed, 0);

    // R7 calibration pulse with rank 5
    wr(32'h0001_00A0);
    check("R7 rcomp pulse", {cal_rcomp, cal_zqcl}, 2'b10);
    check("R7 cal rank", cal_rank, 5);
    @(negedge clk);
    check("R7 rcomp one cycle", cal_rcomp, 0);
    check("R7 rcomp reads 0", cfg_rdata[16], 0);

    // R11 readback after writing all ones (manual mode, nxt=7, all skipped)
    wr(32'hFFFF_FFFF);
    check("R11 readback", cfg_rdata, 32'h0002_7BFE);
    check("R7/R9 pulses", {cal_rcomp, cal_zqcl, fifo_rst}, 3'b111);
    @(negedge clk);
    check("R9 fifo pulse one cycle", fifo_rst, 0);
    check("R8 cke driven", cke_out, 4'hF);
    check("R4 all-ones write ignored", busy, 0);

    // R10 gating
    rx_vld_in = 1'b1;
    @(negedge clk);
    check("R10 gated", rx_vld_out, 0);

    // R8 init_done releases CKE
    init_done = 1'b1;
    @(negedge clk);
    check("R8 cke after init_done", cke_out, 0);
    init_done = 1'b0;
    wr(32'h0000_0000);
    @(negedge clk);
    check("R10 passes", rx_vld_out, 1);
    check("R8 cke released", cke_out, 0);
    rx_vld_in = 1'b0;

    repeat (3) @(negedge clk);
    summary();
  end

endmodule